// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Unit

This unit keeps the program counter and the per-lane enable mask of one warp of 32 lanes. All lanes execute the same instruction under one shared program counter. When a conditional branch splits the lanes, the unit runs the two paths one after the other. The lanes that took the branch run first, at the branch target. The other lanes run next, at the fall-through address. At the reconvergence address the unit restores the mask the warp had before the branch. An eight-entry reconvergence stack lets branches nest inside either path.

Each cycle, an upstream sequencer presents `step` when the instruction at `pc` executes. It raises `is_br` when that instruction is a conditional branch, and then supplies the per-lane predicate, the target, the fall-through address and the reconvergence address. Before anything else, the unit compares `pc` with the reconvergence address of the top stack entry. On a match, that cycle is spent switching paths or reconverging, and any `step` is ignored. A running count of serialized paths shows what divergence costs. A sticky overflow flag reports a nesting level the stack cannot hold.

The controller has three states. `ST_UNIFORM` means the stack is empty and the whole warp is active. `ST_SPLIT` means at least one divergence is open. `ST_FAULT` means a push was attempted with the stack full. The transitions are:
- UNIFORM→SPLIT, on a divergent branch.
- SPLIT→SPLIT, on a nested push, a switch to the pending path, or a pop that leaves entries on the stack.
- SPLIT→UNIFORM, on a pop of the last entry.
- SPLIT→FAULT, on a divergent branch while the stack is full.
- FAULT, which is left only by reset.

Top module: `simt_diverge`

## Requirements
- R1: After reset, `pc` equals the `RESET_PC` parameter (0 by default), `act_mask` has all lanes set, `path_count` is 0 and `overflow` is 0.
- R2: On a cycle with `step` high and `is_br` low, away from a reconvergence match, `pc` advances by 1 on the next edge. On a cycle with `step` low, and no reconvergence match, `pc` and `act_mask` hold.
- R3: A branch is uniform when every active lane agrees. If the effective predicate is zero, `pc` becomes `br_fall`. If it equals the active mask, `pc` becomes `br_tgt`. In both cases `act_mask` and `path_count` do not change and no stack entry is pushed.
- R4: A divergent branch (effective predicate neither zero nor the whole active mask) sets `pc` to `br_tgt` and `act_mask` to the effective predicate, and adds 1 to `path_count`. It records `br_rpc`, `br_fall`, the remaining active lanes and the pre-branch mask in a new stack entry.
- R5: When `pc` equals the top entry's reconvergence address and that entry still has a pending path, `pc` becomes the pending address and `act_mask` becomes the pending lanes, and `path_count` gains 1. `step` is ignored in that cycle.
- R6: When `pc` equals the top entry's reconvergence address and that entry has no pending path, the entry is popped, `act_mask` returns to the pre-branch mask and `pc` stays put. `step` is ignored in that cycle.
- R7: The effective predicate is `br_pred & act_mask`, so a lane that is inactive never becomes active through a nested branch.
- R8: Divergent branches nest up to `DEPTH` (8) levels. Five nested levels that split on successive lane-index bits serialize all 32 lanes one lane per path, for 62 counted path starts, and end with the full mask restored.
- R9: A divergent branch met with `DEPTH` entries already stacked sets `overflow`. From then until reset, `pc`, `act_mask` and `path_count` stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | The instruction at `pc` executes this cycle |
| is_br | input | 1 | The executing instruction is a conditional branch |
| br_pred | input | LANES | Per-lane branch outcome, 1 means taken |
| br_tgt | input | PCW | Branch target address |
| br_fall | input | PCW | Fall-through address |
| br_rpc | input | PCW | Reconvergence address of the branch |
| pc | output | PCW | Current shared program counter |
| act_mask | output | LANES | Current per-lane enable mask |
| overflow | output | 1 | Sticky flag for a push on a full stack |
| path_count | output | CNTW | Number of serialized paths started |

## Verification
The bench builds the block with its default parameters: 32 lanes, an 8-entry stack, 16-bit addresses and a 16-bit path counter. With 32 lanes and depth 8, a five-level binary split reaches the worst case, where every lane runs alone, while leaving three stack entries unused. Nine nested single-lane peel-offs then fill all eight entries and trigger overflow. A hand-built if/else with a uniform branch and a divergent branch nested inside it exercises path switching, popping, and lanes that are already masked off.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

    typedef enum logic [1:0] {
        ST_UNIFORM = 2'd0,
        ST_SPLIT   = 2'd1,
        ST_FAULT   = 2'd2
    } div_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_FLIP = 2'd2,
        OP_POP  = 2'd3
    } stk_op_e;

endpackage

// File: rtl/lane_split.sv
module lane_split #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] pred,
    input  logic [LANES-1:0] cur_mask,
    output logic [LANES-1:0] take_mask,
    output logic [LANES-1:0] rest_mask,
    output logic             none_take,
    output logic             all_take,
    output logic             diverge
);
    // Lanes that are already off cannot take part in the branch
    assign take_mask = pred & cur_mask;
    assign rest_mask = cur_mask & ~pred;
    assign none_take = (take_mask == '0);
    assign all_take  = (rest_mask == '0);
    assign diverge   = !none_take && !all_take;
endmodule

// File: rtl/recon_stack.sv
module recon_stack
    import simt_div_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PCW   = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    input  logic [PCW-1:0]   in_rpc,
    input  logic [PCW-1:0]   in_pc,
    input  logic [LANES-1:0] in_pmask,
    input  logic [LANES-1:0] in_smask,
    output logic             top_valid,
    output logic             top_pend,
    output logic [PCW-1:0]   top_rpc,
    output logic [PCW-1:0]   top_pc,
    output logic [LANES-1:0] top_pmask,
    output logic [LANES-1:0] top_smask,
    output logic             full,
    output logic             last
);
    localparam int DW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0]                 cnt_q;
    logic [IW-1:0]                 top_idx;
    logic [DEPTH-1:0]              pend_all;
    logic [DEPTH-1:0][PCW-1:0]     rpc_all;
    logic [DEPTH-1:0][PCW-1:0]     ppc_all;
    logic [DEPTH-1:0][LANES-1:0]   pm_all;
    logic [DEPTH-1:0][LANES-1:0]   sm_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (op == OP_PUSH) begin
            cnt_q <= cnt_q + DW'(1);
        end else if (op == OP_POP) begin
            cnt_q <= cnt_q - DW'(1);
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            logic             pend_r;
            logic [PCW-1:0]   rpc_r;
            logic [PCW-1:0]   ppc_r;
            logic [LANES-1:0] pm_r;
            logic [LANES-1:0] sm_r;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_r <= 1'b0;
                end else if (op == OP_PUSH && cnt_q == DW'(g)) begin
                    pend_r <= 1'b1;
                end else if (op == OP_FLIP && cnt_q == DW'(g + 1)) begin
                    pend_r <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (op == OP_PUSH && cnt_q == DW'(g)) begin
                    rpc_r <= in_rpc;
                    ppc_r <= in_pc;
                    pm_r  <= in_pmask;
                    sm_r  <= in_smask;
                end
            end

            assign pend_all[g] = pend_r;
            assign rpc_all[g]  = rpc_r;
            assign ppc_all[g]  = ppc_r;
            assign pm_all[g]   = pm_r;
            assign sm_all[g]   = sm_r;
        end
    endgenerate

    assign top_idx   = IW'(cnt_q - DW'(1));
    assign top_valid = (cnt_q != '0);
    assign full      = (cnt_q == DW'(DEPTH));
    assign last      = (cnt_q == DW'(1));
    assign top_pend  = top_valid && pend_all[top_idx];
    assign top_rpc   = rpc_all[top_idx];
    assign top_pc    = ppc_all[top_idx];
    assign top_pmask = pm_all[top_idx];
    assign top_smask = sm_all[top_idx];

    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH) |-> !full);
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP || op == OP_FLIP) |-> (cnt_q != '0));
endmodule

// File: rtl/simt_diverge.sv
module simt_diverge
    import simt_div_pkg::*;
#(
    parameter int             LANES    = 32,
    parameter int             PCW      = 16,
    parameter int             DEPTH    = 8,
    parameter int             CNTW     = 16,
    parameter logic [PCW-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             is_br,
    input  logic [LANES-1:0] br_pred,
    input  logic [PCW-1:0]   br_tgt,
    input  logic [PCW-1:0]   br_fall,
    input  logic [PCW-1:0]   br_rpc,
    output logic [PCW-1:0]   pc,
    output logic [LANES-1:0] act_mask,
    output logic             overflow,
    output logic [CNTW-1:0]  path_count
);
    localparam logic [LANES-1:0] ALL_ON = '1;

    div_state_e       state_q, state_d;
    stk_op_e          op;
    logic [PCW-1:0]   pc_q, pc_d;
    logic [LANES-1:0] mask_q, mask_d;
    logic [CNTW-1:0]  cnt_q, cnt_d;

    logic [LANES-1:0] take_mask, rest_mask;
    logic             none_take, all_take, diverge;
    logic             top_valid, top_pend, full, last;
    logic [PCW-1:0]   top_rpc, top_pc;
    logic [LANES-1:0] top_pmask, top_smask;
    logic             at_rpc;

    lane_split #(.LANES(LANES)) u_split (
        .pred      (br_pred),
        .cur_mask  (mask_q),
        .take_mask (take_mask),
        .rest_mask (rest_mask),
        .none_take (none_take),
        .all_take  (all_take),
        .diverge   (diverge)
    );

    recon_stack #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .in_rpc    (br_rpc),
        .in_pc     (br_fall),
        .in_pmask  (rest_mask),
        .in_smask  (mask_q),
        .top_valid (top_valid),
        .top_pend  (top_pend),
        .top_rpc   (top_rpc),
        .top_pc    (top_pc),
        .top_pmask (top_pmask),
        .top_smask (top_smask),
        .full      (full),
        .last      (last)
    );

    assign at_rpc = top_valid && (pc_q == top_rpc);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNIFORM;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, next outputs and stack command
    always_comb begin
        state_d = state_q;
        op      = OP_NONE;
        pc_d    = pc_q;
        mask_d  = mask_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_UNIFORM, ST_SPLIT: begin
                if (at_rpc) begin
                    if (top_pend) begin
                        op     = OP_FLIP;
                        pc_d   = top_pc;
                        mask_d = top_pmask;
                        cnt_d  = cnt_q + CNTW'(1);
                    end else begin
                        op      = OP_POP;
                        mask_d  = top_smask;
                        state_d = last ? ST_UNIFORM : ST_SPLIT;
                    end
                end else if (step) begin
                    if (!is_br) begin
                        pc_d = pc_q + PCW'(1);
                    end else if (none_take) begin
                        pc_d = br_fall;
                    end else if (all_take) begin
                        pc_d = br_tgt;
                    end else if (full) begin
                        state_d = ST_FAULT;
                    end else begin
                        op      = OP_PUSH;
                        pc_d    = br_tgt;
                        mask_d  = take_mask;
                        cnt_d   = cnt_q + CNTW'(1);
                        state_d = ST_SPLIT;
                    end
                end
            end
            ST_FAULT: begin
                state_d = ST_FAULT;
            end
            default: begin
                state_d = ST_FAULT;
            end
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= RESET_PC;
            mask_q <= ALL_ON;
            cnt_q  <= '0;
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
            cnt_q  <= cnt_d;
        end
    end

    assign pc         = pc_q;
    assign act_mask   = mask_q;
    assign path_count = cnt_q;
    assign overflow   = (state_q == ST_FAULT);

    a_r1_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
        act_mask != '0);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !at_rpc) |=> ($stable(pc) && $stable(act_mask)));
    a_r3_uniform_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (step && is_br && !at_rpc && !overflow && !diverge)
        |=> ($stable(act_mask) && $stable(path_count)));
    a_r4_count_unit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (path_count == $past(path_count)
                  || path_count == $past(path_count) + CNTW'(1)));
    a_r7_no_new_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (step && is_br && !at_rpc && !overflow)
        |=> ((act_mask & ~$past(act_mask)) == '0));
    a_r9_fault_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (overflow && $stable(pc) && $stable(act_mask)
                      && $stable(path_count)));
endmodule

// File: tb/sim_simt_diverge.sv
`timescale 1ns/1ps
module sim_simt_diverge;
    localparam int LANES = 32;
    localparam int PCW   = 16;
    localparam int DEPTH = 8;
    localparam int CNTW  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             step = 1'b0;
    logic             is_br = 1'b0;
    logic [LANES-1:0] br_pred = '0;
    logic [PCW-1:0]   br_tgt = '0;
    logic [PCW-1:0]   br_fall = '0;
    logic [PCW-1:0]   br_rpc = '0;
    logic [PCW-1:0]   pc;
    logic [LANES-1:0] act_mask;
    logic             overflow;
    logic [CNTW-1:0]  path_count;

    simt_diverge #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH), .CNTW(CNTW)) u0 (
        .clk(clk), .rst_n(rst_n), .step(step), .is_br(is_br),
        .br_pred(br_pred), .br_tgt(br_tgt), .br_fall(br_fall), .br_rpc(br_rpc),
        .pc(pc), .act_mask(act_mask), .overflow(overflow), .path_count(path_count)
    );

    always #4 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int          m_pc;
    logic [31:0] m_mask;
    bit          m_ovf;
    int          m_cnt;
    int          q_rpc[$];
    int          q_ppc[$];
    logic [31:0] q_pm[$];
    logic [31:0] q_sm[$];
    bit          q_pf[$];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic mdl_reset();
        m_pc = 0; m_mask = 32'hFFFF_FFFF; m_ovf = 0; m_cnt = 0;
        q_rpc.delete(); q_ppc.delete(); q_pm.delete(); q_sm.delete(); q_pf.delete();
    endtask

    task automatic mdl(input bit st, input bit br, input logic [31:0] pr,
                       input int tg, input int fl, input int rp);
        logic [31:0] eff;
        int          n;
        n = q_rpc.size();
        if (m_ovf) return;
        if (n > 0 && m_pc == q_rpc[n-1]) begin
            if (q_pf[n-1]) begin
                m_pc = q_ppc[n-1]; m_mask = q_pm[n-1]; q_pf[n-1] = 1'b0; m_cnt++;
            end else begin
                m_mask = q_sm[n-1];
                void'(q_rpc.pop_back()); void'(q_ppc.pop_back());
                void'(q_pm.pop_back());  void'(q_sm.pop_back());
                void'(q_pf.pop_back());
            end
        end else if (st) begin
            if (!br) begin
                m_pc = (m_pc + 1) & 16'hFFFF;
            end else begin
                eff = pr & m_mask;
                if (eff == 0) m_pc = fl;
                else if (eff == m_mask) m_pc = tg;
                else if (n == DEPTH) m_ovf = 1;
                else begin
                    q_rpc.push_back(rp); q_ppc.push_back(fl);
                    q_pm.push_back(m_mask & ~eff); q_sm.push_back(m_mask);
                    q_pf.push_back(1'b1);
                    m_pc = tg; m_mask = eff; m_cnt++;
                end
            end
        end
    endtask

    // One clock: drive, let the edge pass, compare everything on the next falling edge
    task automatic cyc(input bit st, input bit br, input logic [31:0] pr,
                       input int tg, input int fl, input int rp);
        step = st; is_br = br; br_pred = pr;
        br_tgt = PCW'(tg); br_fall = PCW'(fl); br_rpc = PCW'(rp);
        @(posedge clk);
        mdl(st, br, pr, tg, fl, rp);
        @(negedge clk);
        chk(cur_req, "pc", 64'(pc), 64'(m_pc & 16'hFFFF));
        chk(cur_req, "mask", 64'(act_mask), 64'(m_mask));
        chk(cur_req, "overflow", 64'(overflow), 64'(m_ovf));
        chk(cur_req, "count", 64'(path_count), 64'(m_cnt & 16'hFFFF));
    endtask

    task automatic walk_to(input int goal);
        for (int k = 0; k < 2000 && m_pc != goal; k++) cyc(1, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0; step = 0; is_br = 0;
        repeat (2) @(negedge clk);
        mdl_reset();
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int          base;
        logic [31:0] leaves;
        logic [31:0] pr;
        int          lvl;

        do_reset();
        // R1 reset values
        chk("R1", "pc", 64'(pc), 64'd0);
        chk("R1", "mask", 64'(act_mask), 64'hFFFF_FFFF);
        chk("R1", "count", 64'(path_count), 64'd0);
        chk("R1", "overflow", 64'(overflow), 64'd0);

        // R2 plain sequencing and hold
        cur_req = "R2";
        repeat (3) cyc(1, 0, 0, 0, 0, 0);
        chk("R2", "pc after 3 steps", 64'(pc), 64'd3);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R2", "pc held", 64'(pc), 64'd3);

        // R3 uniform branches both ways
        cur_req = "R3";
        cyc(1, 1, 32'hFFFF_FFFF, 40, 4, 99);
        chk("R3", "all taken pc", 64'(pc), 64'd40);
        chk("R3", "all taken count", 64'(path_count), 64'd0);
        cyc(1, 1, 32'h0, 90, 60, 99);
        chk("R3", "none taken pc", 64'(pc), 64'd60);
        chk("R3", "none taken mask", 64'(act_mask), 64'hFFFF_FFFF);

        // R4 divergence, R7 nested masking, R5 path switch, R6 reconvergence
        cur_req = "R4";
        cyc(1, 1, 32'h0000_FFFF, 61, 70, 80);
        chk("R4", "taken pc", 64'(pc), 64'd61);
        chk("R4", "taken mask", 64'(act_mask), 64'h0000_FFFF);
        chk("R4", "count", 64'(path_count), 64'd1);
        cur_req = "R7";
        cyc(1, 1, 32'hFFFF_FFFF, 65, 62, 79);
        chk("R7", "idle lanes stay off", 64'(act_mask), 64'h0000_FFFF);
        chk("R7", "treated as uniform", 64'(pc), 64'd65);
        cyc(1, 1, 32'hFFFF_00FF, 66, 67, 75);
        chk("R7", "nested mask", 64'(act_mask), 64'h0000_00FF);
        cur_req = "R5";
        walk_to(75);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R5", "pending pc", 64'(pc), 64'd67);
        chk("R5", "pending mask", 64'(act_mask), 64'h0000_FF00);
        chk("R5", "count", 64'(path_count), 64'd3);
        cur_req = "R6";
        walk_to(75);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R6", "pc stays", 64'(pc), 64'd75);
        chk("R6", "inner restore", 64'(act_mask), 64'h0000_FFFF);
        walk_to(80);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R5", "else pc", 64'(pc), 64'd70);
        chk("R5", "else mask", 64'(act_mask), 64'hFFFF_0000);
        walk_to(80);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R6", "outer restore", 64'(act_mask), 64'hFFFF_FFFF);
        chk("R6", "outer pc", 64'(pc), 64'd80);

        // R8 five-level binary split: every lane alone
        cur_req = "R8";
        walk_to(100);
        base = int'(path_count);
        leaves = 0;
        for (int k = 0; k < 20000 && !(q_rpc.size() == 0 && m_pc == 150); k++) begin
            if (m_pc >= 100 && m_pc <= 104) begin
                lvl = m_pc - 100;
                for (int i = 0; i < 32; i++) pr[i] = ((i >> lvl) & 1) != 0;
                cyc(1, 1, pr, m_pc + 1, m_pc + 1, 150 - lvl);
            end else begin
                cyc((k % 5) != 4, 0, 0, 0, 0, 0);
            end
            if (m_pc == 105) begin
                chk("R8", "leaf lane count", 64'($countones(act_mask)), 64'd1);
                leaves = leaves | act_mask;
            end
        end
        chk("R8", "all lanes ran alone", 64'(leaves), 64'hFFFF_FFFF);
        chk("R8", "paths started", 64'(int'(path_count) - base), 64'd62);
        chk("R8", "mask restored", 64'(act_mask), 64'hFFFF_FFFF);
        chk("R8", "end pc", 64'(pc), 64'd150);

        // R9 nine nested peel-offs overflow the 8-entry stack
        cur_req = "R9";
        walk_to(200);
        base = int'(path_count);
        for (int l = 0; l < 9; l++) cyc(1, 1, ~(32'h1 << l), 201 + l, 201 + l, 260 - l);
        chk("R9", "overflow set", 64'(overflow), 64'd1);
        chk("R9", "pc at fault", 64'(pc), 64'd208);
        chk("R9", "count at fault", 64'(int'(path_count) - base), 64'd8);
        repeat (3) cyc(1, 0, 0, 0, 0, 0);
        chk("R9", "pc frozen", 64'(pc), 64'd208);
        chk("R9", "mask frozen", 64'(act_mask), 64'hFFFF_FF00);

        do_reset();
        cur_req = "R1";
        chk("R1", "overflow cleared", 64'(overflow), 64'd0);
        chk("R1", "pc after reset", 64'(pc), 64'd0);
        cyc(1, 0, 0, 0, 0, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule